// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit compares two IEEE 754 values, either single precision (32-bit) or double precision (64-bit), and records the outcome as a four-bit N/Z/C/V condition pattern in a small status register. When the compare is strobed, the unit also decides whether to raise an invalid-operation exception. That decision depends on whether the caller asked for the quiet or the signaling form of the compare. A sticky bit keeps any raised exception until software-side logic clears it.

The unit has a compare-against-zero form. In that form the second operand is taken to be +0.0 and the `opB` input is not used. Each compare works on one pair of scalars only. The datapath is combinational. Results are registered on the clock edge where `inValid` is high, so they appear on the outputs one cycle after the strobe.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Ordered outcomes set `flagsOut` (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V) as follows: less-than gives 4'b1000, equal gives 4'b0110, greater-than gives 4'b0010.
- R2: If either operand is a NaN (all-ones exponent and a nonzero fraction), the outcome is unordered and `flagsOut` becomes 4'b0011. No less/equal/greater pattern is produced in that case.
- R3: When `signalNan`=0 (quiet form), invalid is raised only if an operand is a signaling NaN, meaning a NaN whose top fraction bit is 0. A quiet NaN (top fraction bit 1) does not raise it.
- R4: When `signalNan`=1 (signaling form), invalid is raised if an operand is any NaN, quiet or signaling.
- R5: When `cmpZero`=1, operand A is compared with +0.0 and `opB` has no effect. A NaN in A still gives the unordered result.
- R6: +0.0 and -0.0 compare equal, in either order and at either precision.
- R7: Ordering follows sign-magnitude rules. When both operands are negative, the order of the raw bit patterns is reversed. Denormals are compared exactly and are never flushed to zero.
- R8: When `isDouble`=0, only bits [31:0] of each operand are used. Bits [63:32] have no effect.
- R9: `invalidSticky` stays set until `clearInvalid` is asserted or reset occurs. If a clear and a compare that raises invalid happen in the same cycle, the bit ends up set.
- R10: After reset, `flagsOut`=0 and `invalidSticky`=0. The outputs change only on a cycle where `inValid` or `clearInvalid` is high, and a result appears one clock after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Strobe: perform a compare and load the result |
| isDouble | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in the low bits |
| cmpZero | input | 1 | 1 = compare operand A with +0.0 |
| signalNan | input | 1 | 1 = signaling form (any NaN raises invalid) |
| clearInvalid | input | 1 | Clears the sticky invalid bit |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| flagsOut | output | 4 | Registered N,Z,C,V result |
| invalidSticky | output | 1 | Sticky invalid-operation bit |

## Verification
If the unit misclassifies a value internally, the error shows on `flagsOut` one clock after the strobe. For example, reading a NaN as ordered, or taking a sign-magnitude order backwards, produces a legal but wrong flag pattern, so each directed compare checks for an exact expected pattern. Faults in the exception path appear only on `invalidSticky`, and only in the cycle after the compare. The bench therefore clears the sticky bit before each NaN case, so that a missing or spurious exception can be seen at the ports. The checks on ignored inputs (`opB` in zero mode, the high bits in single mode) pick operands whose ignored bits would flip the outcome if they were used.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int OP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } cmpRel_t;

  typedef struct packed {
    logic loadFlags;
    logic setInvalid;
    logic clrInvalid;
  } ctrlStrobe_t;

  function automatic logic [3:0] relToNzcv(cmpRel_t rel);
    case (rel)
      REL_LT:  return 4'b1000;
      REL_EQ:  return 4'b0110;
      REL_GT:  return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction
endpackage

// File: rtl/fcmp_format_cmp.sv
module fcmp_format_cmp
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmpRel_t      rel,
  output logic         anyNan,
  output logic         anySnan
);
  logic signA, signB;
  logic [EXP_W-1:0] expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic [W-2:0] magA, magB;
  logic nanA, nanB, snanA, snanB, bothZero, magLess;

  assign signA = a[W-1];
  assign signB = b[W-1];
  assign expA  = a[W-2:FRAC_W];
  assign expB  = b[W-2:FRAC_W];
  assign fracA = a[FRAC_W-1:0];
  assign fracB = b[FRAC_W-1:0];
  assign magA  = a[W-2:0];
  assign magB  = b[W-2:0];

  assign nanA  = (&expA) && (|fracA);
  assign nanB  = (&expB) && (|fracB);
  assign snanA = nanA && !fracA[FRAC_W-1];
  assign snanB = nanB && !fracB[FRAC_W-1];

  assign anyNan   = nanA || nanB;
  assign anySnan  = snanA || snanB;
  assign bothZero = (magA == '0) && (magB == '0);
  assign magLess  = magA < magB;

  always_comb begin
    if (anyNan)                   rel = REL_UN;
    else if (bothZero)            rel = REL_EQ;
    else if (signA != signB)      rel = signA ? REL_LT : REL_GT;
    else if (magA == magB)        rel = REL_EQ;
    else if (magLess ^ signA)     rel = REL_LT;
    else                          rel = REL_GT;
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
(
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  input  logic            isDouble,
  input  logic            cmpZero,
  output cmpRel_t         rel,
  output logic            anyNan,
  output logic            anySnan
);
  localparam int NFMT = 2;

  logic [OP_W-1:0] bEff;
  cmpRel_t fmtRel  [NFMT];
  logic    fmtNan  [NFMT];
  logic    fmtSnan [NFMT];

  assign bEff = cmpZero ? '0 : opB;

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    if (g == 0) begin : g_single
      fcmp_format_cmp #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) i_cmp (
        .a(opA[SP_W-1:0]), .b(bEff[SP_W-1:0]),
        .rel(fmtRel[g]), .anyNan(fmtNan[g]), .anySnan(fmtSnan[g]));
    end else begin : g_double
      fcmp_format_cmp #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) i_cmp (
        .a(opA), .b(bEff),
        .rel(fmtRel[g]), .anyNan(fmtNan[g]), .anySnan(fmtSnan[g]));
    end
  end

  assign rel     = fmtRel[int'(isDouble)];
  assign anyNan  = fmtNan[int'(isDouble)];
  assign anySnan = fmtSnan[int'(isDouble)];
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic        inValid,
  input  logic        signalNan,
  input  logic        clearInvalid,
  input  logic        anyNan,
  input  logic        anySnan,
  output ctrlStrobe_t strobe
);
  logic raise;

  assign raise = signalNan ? anyNan : anySnan;

  always_comb begin
    strobe            = '0;
    strobe.loadFlags  = inValid;
    strobe.setInvalid = inValid && raise;
    strobe.clrInvalid = clearInvalid;
  end
endmodule

// File: rtl/fcmp_status.sv
module fcmp_status
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  cmpRel_t     rel,
  output logic [3:0]  flagsOut,
  output logic        invalidSticky
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsOut      <= 4'b0000;
      invalidSticky <= 1'b0;
    end else begin
      if (strobe.loadFlags) flagsOut <= relToNzcv(rel);
      if (strobe.setInvalid)      invalidSticky <= 1'b1;
      else if (strobe.clrInvalid) invalidSticky <= 1'b0;
    end
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isDouble,
  input  logic        cmpZero,
  input  logic        signalNan,
  input  logic        clearInvalid,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic [3:0]  flagsOut,
  output logic        invalidSticky
);
  cmpRel_t     rel;
  logic        anyNan, anySnan;
  ctrlStrobe_t strobe;

  fcmp_datapath i_datapath (
    .opA(opA), .opB(opB), .isDouble(isDouble), .cmpZero(cmpZero),
    .rel(rel), .anyNan(anyNan), .anySnan(anySnan));

  fcmp_control i_control (
    .inValid(inValid), .signalNan(signalNan), .clearInvalid(clearInvalid),
    .anyNan(anyNan), .anySnan(anySnan), .strobe(strobe));

  fcmp_status i_status (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rel(rel),
    .flagsOut(flagsOut), .invalidSticky(invalidSticky));
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        isDouble,
  input logic        cmpZero,
  input logic        signalNan,
  input logic        clearInvalid,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [3:0]  flagsOut,
  input logic        invalidSticky
);
  logic spNanA;
  assign spNanA = (&opA[30:23]) && (|opA[22:0]);

  assert_flags_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    (flagsOut == 4'b0000 || flagsOut == 4'b1000 || flagsOut == 4'b0110 ||
     flagsOut == 4'b0010 || flagsOut == 4'b0011));

  assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isDouble && spNanA) |=> (flagsOut == 4'b0011));

  assert_signaling_raises_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && signalNan && !isDouble && spNanA) |=> invalidSticky);

  assert_zero_equal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isDouble && !cmpZero && opA[30:0] == 31'd0 && opB[30:0] == 31'd0)
      |=> (flagsOut == 4'b0110));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (invalidSticky && !clearInvalid) |=> invalidSticky);

  assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clearInvalid && !inValid) |=> !invalidSticky);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(flagsOut));
endmodule

bind fcmp_flag_unit fcmp_checker i_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .isDouble(isDouble),
  .cmpZero(cmpZero), .signalNan(signalNan), .clearInvalid(clearInvalid),
  .opA(opA), .opB(opB), .flagsOut(flagsOut), .invalidSticky(invalidSticky));

// File: tb/test_fcmp_flag_unit.sv
module test_fcmp_flag_unit;
  localparam logic [3:0] F_LT = 4'b1000, F_EQ = 4'b0110, F_GT = 4'b0010, F_UN = 4'b0011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, isDouble = 1'b0, cmpZero = 1'b0, signalNan = 1'b0, clearInvalid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [3:0] flagsOut;
  logic invalidSticky;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  fcmp_flag_unit i_fcmp_flag_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isDouble(isDouble),
    .cmpZero(cmpZero), .signalNan(signalNan), .clearInvalid(clearInvalid),
    .opA(opA), .opB(opB), .flagsOut(flagsOut), .invalidSticky(invalidSticky));

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic clearSticky();
    @(negedge clk); clearInvalid = 1'b1;
    @(negedge clk); clearInvalid = 1'b0;
  endtask

  task automatic cmp(logic [63:0] a, logic [63:0] b, logic dbl, logic zero, logic sig,
                     string req, logic [3:0] expF, logic expInv);
    @(negedge clk);
    opA = a; opB = b; isDouble = dbl; cmpZero = zero; signalNan = sig; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, {flagsOut, invalidSticky}, {expF, expInv});
  endtask

  task automatic testReset();
    check("R10 reset", {flagsOut, invalidSticky}, 5'b00000);
  endtask

  task automatic testOrdered();
    cmp(64'h3F800000, 64'h40000000, 0, 0, 0, "R1 sp lt", F_LT, 0);
    cmp(64'h40000000, 64'h3F800000, 0, 0, 0, "R1 sp gt", F_GT, 0);
    cmp(64'h3F800000, 64'h3F800000, 0, 0, 0, "R1 sp eq", F_EQ, 0);
    cmp(64'h3FF0000000000000, 64'h4000000000000000, 1, 0, 1, "R1 dp lt", F_LT, 0);
    cmp(64'h7F800000, 64'h7F800000, 0, 0, 1, "R1 inf eq", F_EQ, 0);
  endtask

  task automatic testSignMag();
    cmp(64'hBF800000, 64'hC0000000, 0, 0, 0, "R7 neg reversed", F_GT, 0);
    cmp(64'hBF800000, 64'h3F800000, 0, 0, 0, "R7 neg vs pos", F_LT, 0);
    cmp(64'h00000001, 64'h00000002, 0, 0, 0, "R7 denormal", F_LT, 0);
    cmp(64'h8000000000000002, 64'h8000000000000001, 1, 0, 0, "R7 dp neg denormal", F_LT, 0);
  endtask

  task automatic testZeros();
    cmp(64'h00000000, 64'h80000000, 0, 0, 0, "R6 sp +0 -0", F_EQ, 0);
    cmp(64'h8000000000000000, 64'h0, 1, 0, 0, "R6 dp -0 +0", F_EQ, 0);
  endtask

  task automatic testNan();
    clearSticky();
    cmp(64'h7FC00000, 64'h3F800000, 0, 0, 0, "R2 R3 quiet qnan", F_UN, 0);
    cmp(64'h3F800000, 64'h7F800001, 0, 0, 0, "R3 quiet snan", F_UN, 1);
    clearSticky();
    check("R9 clear", {flagsOut, invalidSticky}, {F_UN, 1'b0});
    cmp(64'h7FC00000, 64'h3F800000, 0, 0, 1, "R4 signaling qnan", F_UN, 1);
    cmp(64'h3F800000, 64'h40000000, 0, 0, 0, "R9 sticky holds", F_LT, 1);
    clearSticky();
    cmp(64'h7FF0000000000001, 64'h0, 1, 0, 0, "R3 dp snan", F_UN, 1);
    clearSticky();
    cmp(64'h7FF8000000000000, 64'h0, 1, 0, 0, "R3 dp qnan quiet", F_UN, 0);
  endtask

  task automatic testZeroMode();
    clearSticky();
    cmp(64'hBF800000, 64'h7F800001, 0, 1, 1, "R5 zero lt, opB ignored", F_LT, 0);
    cmp(64'h80000000, 64'h40000000, 0, 1, 0, "R5 zero -0 eq", F_EQ, 0);
    cmp(64'h3F800000, 64'h0, 0, 1, 0, "R5 zero gt", F_GT, 0);
    cmp(64'h7FC00000, 64'h0, 0, 1, 1, "R5 zero nan", F_UN, 1);
    clearSticky();
  endtask

  task automatic testUpperIgnored();
    cmp({32'hFFFFFFFF, 32'h3F800000}, {32'h00000000, 32'h40000000}, 0, 0, 1, "R8 high bits", F_LT, 0);
    cmp({32'h7FF80000, 32'h40000000}, {32'h80000000, 32'h3F800000}, 0, 0, 1, "R8 high nan", F_GT, 0);
  endtask

  task automatic testNoStrobe();
    @(negedge clk);
    opA = 64'h7FC00000; opB = 64'h0; isDouble = 0; cmpZero = 0; signalNan = 1;
    @(negedge clk); @(negedge clk);
    check("R10 no strobe", {flagsOut, invalidSticky}, {F_GT, 1'b0});
    @(negedge clk);
    clearInvalid = 1'b1; opA = 64'h7F800001; signalNan = 0; inValid = 1'b1;
    @(negedge clk);
    clearInvalid = 1'b0; inValid = 1'b0;
    check("R9 clear with raise", {flagsOut, invalidSticky}, {F_UN, 1'b1});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrdered();
    testSignMag();
    testZeros();
    testNan();
    testZeroMode();
    testUpperIgnored();
    testNoStrobe();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule